// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Detection

This block is the receive half of a 16550-class UART. It samples the incoming serial line on each pulse of an enable that runs at sixteen times the bit rate. It assembles characters of 5 to 8 data bits, checks parity, and checks the first stop bit. Each finished character goes to an external receive FIFO through a single-cycle strobe that carries the data byte and three flags. The character format is set at run time by plain configuration pins. The format should only be changed while the line is idle.

The block also watches for a break, which is the line held low for a long time. It produces a status level while the break lasts and stores one flagged character per break. It emits a periodic pulse, once per character time, that outside logic counts to build a receive timeout. A loopback select swaps the pin for an internal serial source. An optional registered copy of the 16x enable is available as a baud output.

The FIFO side is a valid-only stream with no back-pressure. The serial line cannot be paused, so `rx_push` is never held or repeated and the FIFO must take the word in the cycle it is offered. Overrun handling belongs to the FIFO.

Top module: `uart_rx_core`

## Requirements
- R1: Idle is detected as high. A low sample on an enable pulse starts a start-bit check. The line is sampled again 8 enable pulses later, and if it is high there the event is dropped as a glitch with no push.
- R2: Data bits are sampled every 16 enable pulses after the start-bit check, least significant bit first. `cfg_len` codes 0, 1, 2, 3 select 5, 6, 7, 8 data bits. `rx_data` bits above the selected length read 0.
- R3: With `cfg_par_en`=1 one parity bit follows the data. With `cfg_par_stick`=0 the parity bit is the XOR of the data bits when `cfg_par_even`=1, and its inverse when `cfg_par_even`=0. With `cfg_par_stick`=1 the parity bit must equal NOT `cfg_par_even`. A mismatch sets `rx_perr`.
- R4: A low first stop bit sets `rx_ferr`. A second stop bit (`cfg_two_stop`=1) is not checked. `rx_brk` is 0 for any character that is not a break.
- R5: `rx_push` is high for exactly one clock per received character, with `rx_data`, `rx_brk`, `rx_perr` and `rx_ferr` valid in that cycle. It has no back-pressure.
- R6: After a good stop bit is sampled the receiver is armed at once. A start bit that begins right after the stop-bit sample point is received.
- R7: A line held low for at least twice the character time (counted in enable pulses) stores exactly one entry, however long the low lasts. That entry has `rx_data`=0, `rx_brk`=1, `rx_ferr`=1 and `rx_perr`=0. `line_brk` is high while the condition lasts and drops once the line returns high, and normal reception then resumes.
- R8: The character time in enable pulses is 16 × (1 start + data bits + parity bit + stop bits). The break threshold follows the current format.
- R9: `rto_tick` pulses for one clock after every character time of enable pulses. Its count restarts only when a character is pushed, and enable pulses in the `rx_push` cycle are not counted.
- R10: With `loop_en`=1 the receiver takes `loop_src` as its line and ignores `rx_pin`.
- R11: When enabled, `baud_out` is the enable input delayed by one clock.
- R12: Under reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| rx_pin | input | 1 | External serial line |
| loop_en | input | 1 | Select internal serial source |
| loop_src | input | 1 | Internal serial source |
| cfg_len | input | 2 | Data length code (0..3 → 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity select |
| cfg_par_stick | input | 1 | Forced parity select |
| cfg_two_stop | input | 1 | Two stop bits |
| rx_push | output | 1 | One-cycle FIFO write strobe |
| rx_data | output | 8 | Received data |
| rx_brk | output | 1 | Break flag of the entry |
| rx_perr | output | 1 | Parity error flag of the entry |
| rx_ferr | output | 1 | Framing error flag of the entry |
| line_brk | output | 1 | Break condition in progress |
| rto_tick | output | 1 | Pulse per character time |
| baud_out | output | 1 | Registered copy of the 16x enable |

## Verification
The bench aims at the corners where receivers usually fail. A long break must yield a single flagged entry; a design that re-armed inside the break would push a stream of zero characters. A stop bit cut short just after its sample point, with a start bit right behind it, must still be received; a receiver that waits for a spell of high line would lose the second character. The break threshold is probed just below and just above twice the character time for both a short and a long format, which catches a fixed threshold. The timeout pulse spacing is measured in enable pulses for two formats, which shows whether the period tracks the format and whether it runs freely between pushes.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int unsigned DATA_MAX = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD,
    RX_BRKEND
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
    logic       two_stop;
  } rx_fmt_t;

  typedef struct packed {
    logic                brk;
    logic                perr;
    logic                ferr;
    logic [DATA_MAX-1:0] data;
  } rx_word_t;

  // bit periods in one character: start + data + parity + stop(s)
  function automatic logic [3:0] frame_bits(rx_fmt_t f);
    return 4'd7 + {2'b00, f.len} + {3'b000, f.par_en} + {3'b000, f.two_stop};
  endfunction

endpackage

// File: rtl/uart_rx_front.sv
module uart_rx_front #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  input  logic loop_en,
  input  logic loop_src,
  output logic rx_s
);

  logic line_sel;
  logic [STAGES-1:0] chain;

  assign line_sel = loop_en ? loop_src : rx_pin;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= line_sel;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_sel};
      end
    end
  endgenerate

  assign rx_s = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_lowtimer.sv
module uart_rx_lowtimer #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         rx_s,
  input  logic [W-1:0] limit,
  output logic         brk_line
);

  logic [W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                       low_cnt <= '0;
    else if (rx_s)                    low_cnt <= '0;
    else if (tick && low_cnt != '1)   low_cnt <= low_cnt + W'(1);
  end

  assign brk_line = (low_cnt >= limit) && (limit != '0);

endmodule

// File: rtl/uart_rx_chartimer.sv
module uart_rx_chartimer #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         restart,
  input  logic [W-1:0] period,
  output logic         pulse
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (restart) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt >= period - W'(1)) begin
          cnt   <= '0;
          pulse <= 1'b1;
        end else begin
          cnt <= cnt + W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter bit ENABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic baud
);

  generate
    if (ENABLE) begin : g_on
      always_ff @(posedge clk) begin
        if (!rst_n) baud <= 1'b0;
        else        baud <= tick;
      end
    end else begin : g_off
      assign baud = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     rx_s,
  input  rx_fmt_t  fmt,
  input  logic     brk_line,
  output logic     push,
  output rx_word_t word
);

  localparam int unsigned SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] MID  = SUB_W'(OVS / 2 - 1);
  localparam logic [SUB_W-1:0] LAST = SUB_W'(OVS - 1);

  rx_state_e           state;
  logic [SUB_W-1:0]    sub;
  logic [2:0]          bitn;
  logic [DATA_MAX-1:0] shreg;
  logic                par_acc;
  logic                perr_q;
  logic [2:0]          last_bit;
  logic                exp_par;

  assign last_bit = 3'd4 + {1'b0, fmt.len};
  assign exp_par  = fmt.par_stick ? ~fmt.par_even
                  : (fmt.par_even ? par_acc : ~par_acc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      sub     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      par_acc <= 1'b0;
      perr_q  <= 1'b0;
      push    <= 1'b0;
      word    <= '0;
    end else begin
      push <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (tick && !rx_s) begin
            state <= RX_START;
            sub   <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (sub == MID) begin
              if (rx_s) begin
                state <= RX_IDLE;
              end else begin
                state   <= RX_DATA;
                sub     <= '0;
                bitn    <= '0;
                shreg   <= '0;
                par_acc <= 1'b0;
                perr_q  <= 1'b0;
              end
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (sub == LAST) begin
              sub         <= '0;
              shreg[bitn] <= rx_s;
              par_acc     <= par_acc ^ rx_s;
              bitn        <= bitn + 3'd1;
              if (bitn == last_bit) state <= fmt.par_en ? RX_PAR : RX_STOP;
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
        end
        RX_PAR: begin
          if (tick) begin
            if (sub == LAST) begin
              sub    <= '0;
              perr_q <= (rx_s != exp_par);
              state  <= RX_STOP;
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (sub == LAST) begin
              sub <= '0;
              if (rx_s) begin
                push       <= 1'b1;
                word.brk   <= 1'b0;
                word.perr  <= perr_q;
                word.ferr  <= 1'b0;
                word.data  <= shreg;
                state      <= RX_IDLE;
              end else begin
                state <= RX_HOLD;
              end
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
        end
        RX_HOLD: begin
          if (brk_line) begin
            push      <= 1'b1;
            word.brk  <= 1'b1;
            word.perr <= 1'b0;
            word.ferr <= 1'b1;
            word.data <= '0;
            state     <= RX_BRKEND;
          end else if (rx_s) begin
            push      <= 1'b1;
            word.brk  <= 1'b0;
            word.perr <= perr_q;
            word.ferr <= 1'b1;
            word.data <= shreg;
            state     <= RX_IDLE;
          end
        end
        RX_BRKEND: begin
          if (rx_s) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned OVS          = 16,
  parameter int unsigned TMR_W        = 10,
  parameter bit          HAS_BAUD_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_pin,
  input  logic       loop_en,
  input  logic       loop_src,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_par_stick,
  input  logic       cfg_two_stop,
  output logic       rx_push,
  output logic [7:0] rx_data,
  output logic       rx_brk,
  output logic       rx_perr,
  output logic       rx_ferr,
  output logic       line_brk,
  output logic       rto_tick,
  output logic       baud_out
);

  localparam int unsigned OVS_SH = $clog2(OVS);

  rx_fmt_t          fmt;
  rx_word_t         word;
  logic             rx_s;
  logic [3:0]       bits;
  logic [TMR_W-1:0] char_ticks;
  logic [TMR_W-1:0] brk_limit;

  assign fmt.len       = cfg_len;
  assign fmt.par_en    = cfg_par_en;
  assign fmt.par_even  = cfg_par_even;
  assign fmt.par_stick = cfg_par_stick;
  assign fmt.two_stop  = cfg_two_stop;

  assign bits       = frame_bits(fmt);
  assign char_ticks = TMR_W'(bits) << OVS_SH;
  assign brk_limit  = TMR_W'(bits) << (OVS_SH + 1);

  uart_rx_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin),
    .loop_en(loop_en), .loop_src(loop_src), .rx_s(rx_s)
  );

  uart_rx_lowtimer #(.W(TMR_W)) u_low (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_s(rx_s),
    .limit(brk_limit), .brk_line(line_brk)
  );

  uart_rx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_s(rx_s),
    .fmt(fmt), .brk_line(line_brk), .push(rx_push), .word(word)
  );

  uart_rx_chartimer #(.W(TMR_W)) u_char (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .restart(rx_push),
    .period(char_ticks), .pulse(rto_tick)
  );

  uart_rx_baud #(.ENABLE(HAS_BAUD_OUT)) u_baud (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .baud(baud_out)
  );

  assign rx_data = word.data;
  assign rx_brk  = word.brk;
  assign rx_perr = word.perr;
  assign rx_ferr = word.ferr;

endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
  parameter bit BAUD_ON = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick16,
  input logic       rx_s,
  input logic       rx_push,
  input logic [7:0] rx_data,
  input logic       rx_brk,
  input logic       rx_perr,
  input logic       rx_ferr,
  input logic       line_brk,
  input logic       rto_tick,
  input logic       baud_out
);

  // R5
  push_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);

  // R7
  brk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_brk) |-> (rx_ferr && !rx_perr && rx_data == 8'h00));

  // R7
  brk_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_s |=> !line_brk);

  // R9
  rto_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rto_tick |-> $past(tick16));

  // R9
  rto_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rto_tick |=> !rto_tick);

  generate
    if (BAUD_ON) begin : g_baud
      // R11
      baud_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick16 |=> baud_out);
      // R11
      baud_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick16 |=> !baud_out);
    end
  endgenerate

endmodule

bind uart_rx_core uart_rx_core_chk #(.BAUD_ON(HAS_BAUD_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_s(rx_s),
  .rx_push(rx_push), .rx_data(rx_data), .rx_brk(rx_brk),
  .rx_perr(rx_perr), .rx_ferr(rx_ferr), .line_brk(line_brk),
  .rto_tick(rto_tick), .baud_out(baud_out)
);

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_CLKS  = 2;
  localparam int WATCHDOG   = 190000;
  localparam int NV         = 10;

  // {len[1:0], par_en, par_even, par_stick, two_stop, bad_par, bad_stop, data[7:0]}
  localparam logic [15:0] VEC [NV] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C},
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h81},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF},
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h2A},
    {2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h55},
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC3},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h7E},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h6B},
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_pin = 1'b1;
  logic       loop_en = 1'b0;
  logic       loop_src = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_par_stick = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       rx_push, rx_brk, rx_perr, rx_ferr, line_brk, rto_tick, baud_out;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int ncap = 0;
  logic [10:0] cap [64];
  logic drv_loop = 1'b0;

  uart_rx_core u_uart_rx_core (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_pin(rx_pin),
    .loop_en(loop_en), .loop_src(loop_src), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .cfg_two_stop(cfg_two_stop),
    .rx_push(rx_push), .rx_data(rx_data), .rx_brk(rx_brk),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .line_brk(line_brk),
    .rto_tick(rto_tick), .baud_out(baud_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) tick16 <= 1'b0;
    else        tick16 <= ~tick16;
  end

  always @(negedge clk) begin
    if (rst_n && rx_push) begin
      cap[ncap % 64] = {rx_brk, rx_perr, rx_ferr, rx_data};
      ncap++;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual cycles %0d expected below %0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v);
    if (drv_loop) loop_src = v;
    else          rx_pin   = v;
  endtask

  task automatic send_bit(input logic v, input int nticks);
    drive(v);
    repeat (nticks * TICK_CLKS) @(negedge clk);
  endtask

  task automatic set_fmt(input logic [15:0] v);
    cfg_len       = v[15:14];
    cfg_par_en    = v[13];
    cfg_par_even  = v[12];
    cfg_par_stick = v[11];
    cfg_two_stop  = v[10];
  endtask

  function automatic logic [7:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  function automatic int char_ticks(input logic [15:0] v);
    return 16 * (7 + int'(v[15:14]) + int'(v[13]) + int'(v[10]));
  endfunction

  task automatic send_frame(input logic [15:0] v, input int stop_ticks);
    logic [7:0] d;
    logic       pb;
    d = v[7:0] & len_mask(v[15:14]);
    send_bit(1'b0, 16);
    for (int b = 0; b < 5 + int'(v[15:14]); b++) send_bit(d[b], 16);
    if (v[13]) begin
      pb = v[11] ? ~v[12] : (v[12] ? ^d : ~(^d));
      send_bit(pb ^ v[9], 16);
    end
    if (v[8]) begin
      send_bit(1'b0, 16);
    end else begin
      send_bit(1'b1, stop_ticks);
      if (v[10]) send_bit(1'b1, 16);
    end
  endtask

  task automatic measure_rto(input int exp, input string tag);
    int n;
    while (!rx_push) @(negedge clk);
    @(negedge clk);
    n = 0;
    while (!rto_tick) begin
      if (tick16) n++;
      @(negedge clk);
    end
    chk(n == exp, tag, "first interval ticks", n, exp);
    n = 0;
    if (tick16) n++;
    @(negedge clk);
    while (!rto_tick) begin
      if (tick16) n++;
      @(negedge clk);
    end
    chk(n == exp, tag, "free-running interval ticks", n, exp);
  endtask

  initial begin
    int base;
    logic [10:0] w;
    logic [15:0] v;
    logic [7:0]  ed;

    // R12: outputs under reset
    repeat (4) @(negedge clk);
    chk({rx_push, rx_brk, rx_perr, rx_ferr, line_brk, rto_tick, baud_out} == 7'd0,
        "R12", "flags during reset", int'({rx_push, rx_brk, rx_perr, rx_ferr, line_brk, rto_tick, baud_out}), 0);
    chk(rx_data == 8'h00, "R12", "data during reset", int'(rx_data), 0);
    rst_n = 1'b1;
    send_bit(1'b1, 32);
    chk(ncap == 0 && !line_brk, "R12", "quiet after reset", ncap, 0);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      set_fmt(v);
      send_bit(1'b1, 32);
      base = ncap;
      send_frame(v, 16);
      send_bit(1'b1, 32);
      chk(ncap == base + 1, "R5", "push count", ncap - base, 1);
      w  = cap[base % 64];
      ed = v[7:0] & len_mask(v[15:14]);
      chk(w[7:0] == ed, "R2", "data", int'(w[7:0]), int'(ed));
      chk(w[9] == (v[13] & v[9]), "R3", "parity flag", int'(w[9]), int'(v[13] & v[9]));
      chk(w[8] == v[8], "R4", "framing flag", int'(w[8]), int'(v[8]));
      chk(w[10] == 1'b0, "R4", "break flag", int'(w[10]), 0);
    end

    // R1: short low pulse is a glitch
    set_fmt(16'hC000);
    base = ncap;
    send_bit(1'b0, 4);
    send_bit(1'b1, 48);
    chk(ncap == base, "R1", "glitch pushes", ncap - base, 0);

    // R6: start bit right after a shortened stop bit
    base = ncap;
    send_frame(16'hC0A5, 10);
    send_frame(16'hC05A, 16);
    send_bit(1'b1, 32);
    chk(ncap == base + 2, "R6", "back-to-back pushes", ncap - base, 2);
    chk(cap[base % 64] == 11'h0A5, "R6", "first char", int'(cap[base % 64]), 'h0A5);
    chk(cap[(base + 1) % 64] == 11'h05A, "R6", "second char", int'(cap[(base + 1) % 64]), 'h05A);

    // R7: long break gives one entry, then normal reception
    base = ncap;
    send_bit(1'b0, 800);
    chk(line_brk == 1'b1, "R7", "line_brk during break", int'(line_brk), 1);
    send_bit(1'b1, 3);
    chk(line_brk == 1'b0, "R7", "line_brk after release", int'(line_brk), 0);
    send_bit(1'b1, 32);
    chk(ncap == base + 1, "R7", "break pushes", ncap - base, 1);
    chk(cap[base % 64] == 11'h500, "R7", "break entry", int'(cap[base % 64]), 'h500);
    send_frame(16'hC03C, 16);
    send_bit(1'b1, 32);
    chk(ncap == base + 2 && cap[(base + 1) % 64] == 11'h03C, "R7", "char after break",
        int'(cap[(base + 1) % 64]), 'h03C);

    // R8: threshold follows format (5N1 = 224 ticks, 8E2 = 384 ticks)
    set_fmt(16'h0000);
    base = ncap;
    send_bit(1'b0, 250);
    chk(line_brk == 1'b1, "R8", "5N1 line_brk at 250", int'(line_brk), 1);
    send_bit(1'b1, 32);
    set_fmt(16'hF400);
    send_bit(1'b0, 300);
    chk(line_brk == 1'b0, "R8", "8E2 line_brk at 300", int'(line_brk), 0);
    send_bit(1'b0, 120);
    chk(line_brk == 1'b1, "R8", "8E2 line_brk at 420", int'(line_brk), 1);
    send_bit(1'b1, 32);
    chk(ncap == base + 2, "R8", "one entry per break", ncap - base, 2);

    // R9: character-time pulse, two formats
    set_fmt(16'hC000);
    send_bit(1'b1, 32);
    fork
      begin send_frame(16'hC011, 16); send_bit(1'b1, 16); end
      measure_rto(char_ticks(16'hC000), "R9");
    join
    set_fmt(16'h0000);
    send_bit(1'b1, 32);
    fork
      begin send_frame(16'h0011, 16); send_bit(1'b1, 16); end
      measure_rto(char_ticks(16'h0000), "R9");
    join

    // R10: loopback ignores the pin
    set_fmt(16'hC000);
    loop_src = 1'b1;
    loop_en  = 1'b1;
    send_bit(1'b1, 4);
    rx_pin   = 1'b0;
    drv_loop = 1'b1;
    send_bit(1'b1, 32);
    base = ncap;
    send_frame(16'hC096, 16);
    send_bit(1'b1, 32);
    chk(ncap == base + 1 && cap[base % 64] == 11'h096, "R10", "loopback char",
        int'(cap[base % 64]), 'h096);
    chk(line_brk == 1'b0, "R10", "pin low not seen", int'(line_brk), 0);
    drv_loop = 1'b0;
    rx_pin   = 1'b1;
    send_bit(1'b1, 4);
    loop_en  = 1'b0;

    // R11: baud output follows the enable by one clock
    for (int k = 0; k < 8; k++) begin
      logic prev;
      prev = tick16;
      @(negedge clk);
      chk(baud_out == prev, "R11", "baud_out", int'(baud_out), int'(prev));
    end

    summary();
  end

endmodule